// File: doc/BRIEF.md
# Acknowledgement Frame Octet Builder

This block assembles the short acknowledgement frame of a low-rate personal-area-network transmitter and delivers it one octet at a time to the symbol stage. A single start pulse captures a 3-bit frame-type code, four control flag bits and an 8-bit sequence number. The block then presents eleven octets (88 bits) on a valid/ready byte interface: a run of zero preamble octets, a start-of-frame delimiter, the length octet, the two frame-control octets, the sequence number, and finally the two frame-check octets.

The frame-check value comes from a CRC-16 unit inside the block. That unit is cleared when a frame is accepted and is fed only the octets that the frame check covers: the two frame-control octets and the sequence number. The last octet carries an end marker. Start requests that arrive while a frame is still in flight are dropped.

Top module: `ack_frame_asm`

## Requirements
- R1: After reset, valid_o and last_o are low.
- R2: A start_i pulse while idle raises valid_o on the next cycle. The first octets are then 4 octets of 0x00, 0xA7, and the length value 0x05.
- R3: Octet 6 (counting from 0) is the low frame-control octet: bits [2:0] are frame_type_i, bits [6:3] are flags_i and bit 7 is 0. Octet 7 is the high frame-control octet, 0x00.
- R4: Octet 8 is the sequence number captured at start.
- R5: Octets 9 and 10 are the frame-check value, low octet first. It is a CRC-16 with generator x^16+x^15+x^2+1 and initial value 0, computed over octets 6, 7 and 8 in that order, with each octet taken LSB first (reflected form, constant 0xA001).
- R6: While valid_o is high and ready_i is low, data_o and last_o hold their values and valid_o stays high.
- R7: last_o is high only together with valid_o, and only on the 11th octet of the frame.
- R8: start_i, and changes on frame_type_i, flags_i and seq_num_i, have no effect on a frame in progress. This includes the cycle in which the last octet is accepted.
- R9: In the cycle after the last octet is accepted, valid_o is low. The block then accepts a new start.
- R10: The frame-check value is recomputed from zero for every frame. Two frames with the same inputs carry the same check octets, and a frame with different inputs carries the check value of its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a frame when the block is idle |
| frame_type_i | input | 3 | Frame-type code placed in frame control (0b010 for acknowledgement) |
| flags_i | input | 4 | Control flag bits placed in frame control |
| seq_num_i | input | 8 | Sequence number of the frame |
| data_o | output | 8 | Current output octet |
| valid_o | output | 1 | data_o holds a frame octet |
| ready_i | input | 1 | Downstream accepts the octet |
| last_o | output | 1 | Marks the final octet of the frame |

## Verification
The assertions check, on every cycle, the handshake rules and the frame framing: octets are held under back-pressure, the end marker falls on the 11th accepted octet, the preamble, delimiter and length octets sit at their fixed positions, a started frame produces valid output, and valid drops after the end. Only the bench scenarios can show that the frame-control packing, the sequence number and the CRC octets match what is expected for a given set of inputs. The same holds for two more behaviours. Inputs and start requests applied during a frame must leave its content unchanged. The check value must start again from zero for each new frame.

// File: rtl/ack_pkg.sv
package ack_pkg;
  localparam int OCTET_W = 8;
  localparam int CRC_W   = 16;

  typedef enum logic [2:0] {
    FT_BEACON = 3'b000,
    FT_DATA   = 3'b001,
    FT_ACK    = 3'b010,
    FT_CMD    = 3'b011
  } frame_type_e;

  typedef struct packed {
    logic [7:0] hi;
    logic       rsvd;
    logic [3:0] flags;
    logic [2:0] ftype;
  } frame_ctrl_t;

  // One octet through a reflected CRC, LSB first
  function automatic logic [CRC_W-1:0] crc_octet(input logic [CRC_W-1:0] crc_in,
                                                 input logic [OCTET_W-1:0] octet,
                                                 input logic [CRC_W-1:0] poly_refl);
    logic [CRC_W-1:0] c;
    c = crc_in;
    for (int b = 0; b < OCTET_W; b++) begin
      if (c[0] ^ octet[b]) c = (c >> 1) ^ poly_refl;
      else                 c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/ack_crc16.sv
module ack_crc16
  import ack_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY_REFL = 16'hA001,
  parameter logic [CRC_W-1:0] INIT      = 16'h0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic [OCTET_W-1:0] octet_i,
  output logic [CRC_W-1:0]   crc_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= INIT;
    else if (clr_i) crc_q <= INIT;
    else if (en_i)  crc_q <= crc_octet(crc_q, octet_i, POLY_REFL);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/ack_seq_ctrl.sv
module ack_seq_ctrl #(
  parameter int FRAME_LEN = 11,
  localparam int IDX_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ready_i,
  output logic             active_o,
  output logic             load_o,
  output logic             fire_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  assign load_o   = start_i && !active_q;
  assign fire_o   = active_q && ready_i;
  assign last_o   = active_q && (idx_q == LAST_IDX);
  assign active_o = active_q;
  assign idx_o    = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (load_o) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (fire_o) begin
      if (idx_q == LAST_IDX) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ack_octet_mux.sv
module ack_octet_mux
  import ack_pkg::*;
#(
  parameter int                 PREAMBLE_LEN = 4,
  parameter logic [OCTET_W-1:0] PRE_OCTET    = 8'h00,
  parameter logic [OCTET_W-1:0] SFD_OCTET    = 8'hA7,
  parameter logic [OCTET_W-1:0] LEN_OCTET    = 8'h05,
  localparam int FRAME_LEN = PREAMBLE_LEN + 7,
  localparam int IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic [IDX_W-1:0]   idx_i,
  input  frame_ctrl_t        fc_i,
  input  logic [OCTET_W-1:0] seq_i,
  input  logic [CRC_W-1:0]   crc_i,
  output logic [OCTET_W-1:0] octet_o
);
  localparam logic [IDX_W-1:0] P_SFD  = IDX_W'(PREAMBLE_LEN);
  localparam logic [IDX_W-1:0] P_LEN  = IDX_W'(PREAMBLE_LEN + 1);
  localparam logic [IDX_W-1:0] P_FCL  = IDX_W'(PREAMBLE_LEN + 2);
  localparam logic [IDX_W-1:0] P_FCH  = IDX_W'(PREAMBLE_LEN + 3);
  localparam logic [IDX_W-1:0] P_SEQ  = IDX_W'(PREAMBLE_LEN + 4);
  localparam logic [IDX_W-1:0] P_CRCL = IDX_W'(PREAMBLE_LEN + 5);
  localparam logic [IDX_W-1:0] P_CRCH = IDX_W'(PREAMBLE_LEN + 6);

  logic [15:0] fc_bits;
  assign fc_bits = fc_i;

  always_comb begin
    octet_o = PRE_OCTET;
    unique case (idx_i)
      P_SFD:   octet_o = SFD_OCTET;
      P_LEN:   octet_o = LEN_OCTET;
      P_FCL:   octet_o = fc_bits[7:0];
      P_FCH:   octet_o = fc_bits[15:8];
      P_SEQ:   octet_o = seq_i;
      P_CRCL:  octet_o = crc_i[7:0];
      P_CRCH:  octet_o = crc_i[15:8];
      default: octet_o = PRE_OCTET;
    endcase
  end
endmodule

// File: rtl/ack_frame_asm.sv
module ack_frame_asm
  import ack_pkg::*;
#(
  parameter int                 PREAMBLE_LEN = 4,
  parameter logic [OCTET_W-1:0] SFD_OCTET    = 8'hA7,
  parameter logic [CRC_W-1:0]   POLY_REFL    = 16'hA001,
  localparam int MPDU_LEN  = 5,
  localparam int FRAME_LEN = PREAMBLE_LEN + 2 + MPDU_LEN,
  localparam int IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   frame_type_i,
  input  logic [3:0]   flags_i,
  input  logic [7:0]   seq_num_i,
  output logic [7:0]   data_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic         last_o
);
  localparam logic [IDX_W-1:0] CRC_FIRST = IDX_W'(PREAMBLE_LEN + 2);
  localparam logic [IDX_W-1:0] CRC_LAST  = IDX_W'(PREAMBLE_LEN + 4);

  logic             active, load, fire, last;
  logic [IDX_W-1:0] idx;
  frame_ctrl_t      fc_q;
  logic [7:0]       seq_q;
  logic [CRC_W-1:0] crc;
  logic [7:0]       octet;
  logic             crc_en;

  ack_seq_ctrl #(.FRAME_LEN(FRAME_LEN)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .ready_i,
    .active_o(active), .load_o(load), .fire_o(fire),
    .last_o(last), .idx_o(idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fc_q  <= '0;
      seq_q <= '0;
    end else if (load) begin
      fc_q.hi    <= 8'h00;
      fc_q.rsvd  <= 1'b0;
      fc_q.flags <= flags_i;
      fc_q.ftype <= frame_type_i;
      seq_q      <= seq_num_i;
    end
  end

  // Only frame control and sequence octets enter the check
  assign crc_en = fire && (idx >= CRC_FIRST) && (idx <= CRC_LAST);

  ack_crc16 #(.POLY_REFL(POLY_REFL), .INIT(16'h0000)) u_crc (
    .clk_i, .rst_ni, .clr_i(load), .en_i(crc_en),
    .octet_i(octet), .crc_o(crc)
  );

  ack_octet_mux #(
    .PREAMBLE_LEN(PREAMBLE_LEN), .PRE_OCTET(8'h00),
    .SFD_OCTET(SFD_OCTET), .LEN_OCTET(8'(MPDU_LEN))
  ) u_mux (
    .idx_i(idx), .fc_i(fc_q), .seq_i(seq_q), .crc_i(crc), .octet_o(octet)
  );

  assign data_o  = octet;
  assign valid_o = active;
  assign last_o  = last;
endmodule

// File: rtl/ack_frame_asm_chk.sv
module ack_frame_asm_chk #(
  parameter int          PREAMBLE_LEN = 4,
  parameter logic [7:0]  SFD_OCTET    = 8'hA7,
  localparam int FRAME_LEN = PREAMBLE_LEN + 7,
  localparam int CNT_W     = $clog2(FRAME_LEN)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       ready_i,
  input logic       valid_o,
  input logic       last_o,
  input logic [7:0] data_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (valid_o && ready_i) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> !valid_o && !last_o);

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !valid_o |=> valid_o);

  p_preamble_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && (cnt_q < CNT_W'(PREAMBLE_LEN)) |-> data_o == 8'h00);

  p_sfd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && (cnt_q == CNT_W'(PREAMBLE_LEN)) |-> data_o == SFD_OCTET);

  p_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && (cnt_q == CNT_W'(PREAMBLE_LEN + 1)) |-> data_o == 8'h05);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(last_o));

  p_last_pos_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o && (cnt_q == CNT_W'(FRAME_LEN - 1)));

  p_last_due_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && (cnt_q == CNT_W'(FRAME_LEN - 1)) |-> last_o);

  p_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !(ready_i && last_o) |=> valid_o);

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && last_o |=> !valid_o);
endmodule

bind ack_frame_asm ack_frame_asm_chk #(
  .PREAMBLE_LEN(PREAMBLE_LEN), .SFD_OCTET(SFD_OCTET)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ready_i(ready_i),
  .valid_o(valid_o), .last_o(last_o), .data_o(data_o)
);

// File: tb/ack_frame_asm_test.sv
`timescale 1ns/1ps
module ack_frame_asm_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] frame_type_i = '0;
  logic [3:0] flags_i = '0;
  logic [7:0] seq_num_i = '0;
  logic [7:0] data_o;
  logic       valid_o;
  logic       ready_i = 1'b0;
  logic       last_o;

  int checks = 0;
  int failures = 0;
  logic [15:0] prev_fcs;
  logic [15:0] last_fcs;

  always #5 clk_i = ~clk_i;

  ack_frame_asm uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // CRC-16 x^16+x^15+x^2+1, init 0, bits LSB first
  function automatic logic [15:0] ref_crc(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    logic [23:0] stream;
    logic [15:0] r;
    logic fb;
    stream = {c, b, a};
    r = 16'h0;
    for (int i = 0; i < 24; i++) begin
      fb = r[0] ^ stream[i];
      r = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'hA001;
    end
    return r;
  endfunction

  // mode 0: ready always; 1: stall pattern; disturb: toggle inputs/start mid-frame
  task automatic run_frame(input logic [2:0] ft, input logic [3:0] fl, input logic [7:0] sq,
                           input int mode, input bit disturb, input string tag);
    logic [7:0] exp [11];
    logic [15:0] crc;
    int k, cyc;
    logic [7:0] held;
    bit was_stall;
    exp[0] = 8'h00; exp[1] = 8'h00; exp[2] = 8'h00; exp[3] = 8'h00;
    exp[4] = 8'hA7; exp[5] = 8'h05;
    exp[6] = {1'b0, fl, ft}; exp[7] = 8'h00; exp[8] = sq;
    crc = ref_crc(exp[6], exp[7], exp[8]);
    exp[9] = crc[7:0]; exp[10] = crc[15:8];
    last_fcs = crc;

    @(negedge clk_i);
    frame_type_i = ft; flags_i = fl; seq_num_i = sq; start_i = 1'b1; ready_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(valid_o == 1'b1, {"R2 valid after start ", tag}, valid_o, 1);
    k = 0; cyc = 0; was_stall = 0; held = 8'h00;
    while (k < 11 && cyc < 200) begin
      if (disturb) begin
        start_i = 1'b1; frame_type_i = ~ft; flags_i = ~fl; seq_num_i = ~sq;
      end
      ready_i = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      chk(valid_o == 1'b1, {"R8 valid mid-frame ", tag}, valid_o, 1);
      if (k >= 6 && k <= 8)
        chk(data_o == exp[k], {(k == 8) ? "R4 seq octet " : "R3 frame control ", tag}, data_o, exp[k]);
      else if (k >= 9)
        chk(data_o == exp[k], {"R5 check octet ", tag}, data_o, exp[k]);
      else
        chk(data_o == exp[k], {"R2 header octet ", tag}, data_o, exp[k]);
      chk(last_o == (k == 10), {"R7 last marker ", tag}, last_o, (k == 10));
      if (was_stall)
        chk(data_o == held, {"R6 hold under stall ", tag}, data_o, held);
      was_stall = !ready_i;
      held = data_o;
      if (ready_i) k++;
      cyc++;
      @(negedge clk_i);
    end
    chk(k == 11, {"R2 octet count ", tag}, k, 11);
    chk(valid_o == 1'b0, {"R9 idle after last ", tag}, valid_o, 0);
    chk(last_o == 1'b0, {"R7 no last when idle ", tag}, last_o, 0);
    start_i = 1'b0; ready_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #1;
    chk(valid_o == 1'b0, "R1 valid in reset", valid_o, 0);
    chk(last_o == 1'b0, "R1 last in reset", last_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R1 valid after reset", valid_o, 0);
  endtask

  task automatic t_basic();
    run_frame(3'b010, 4'h0, 8'h3C, 0, 0, "ack");
    run_frame(3'b001, 4'h5, 8'h00, 0, 0, "data");
    run_frame(3'b111, 4'hF, 8'hFF, 0, 0, "allones");
  endtask

  task automatic t_stall();
    run_frame(3'b010, 4'hA, 8'h81, 1, 0, "stall");
  endtask

  task automatic t_disturb();
    run_frame(3'b010, 4'h2, 8'h5A, 1, 1, "disturb R8");
  endtask

  task automatic t_crc_restart();
    run_frame(3'b010, 4'h3, 8'h77, 0, 0, "crc first");
    prev_fcs = last_fcs;
    run_frame(3'b010, 4'h3, 8'h77, 0, 0, "crc repeat R10");
    chk(prev_fcs == last_fcs, "R10 same inputs same check", last_fcs, prev_fcs);
    run_frame(3'b000, 4'h1, 8'h12, 0, 0, "crc new R10");
  endtask

  task automatic t_idle_inputs();
    @(negedge clk_i);
    frame_type_i = 3'b101; seq_num_i = 8'hEE; ready_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R9 idle without start", valid_o, 0);
    ready_i = 1'b0;
  endtask

  initial begin
    #(500_000 * 1ns);
    failures++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_stall();
    t_disturb();
    t_crc_restart();
    t_idle_inputs();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule